// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block divides the system clock by a programmable 16-bit divisor and emits a one-clock enable pulse, the sample tick, at sixteen times the serial bit rate. A transmitter and a receiver elsewhere in the serial channel both use this tick to step their state. The divisor is held in two byte-wide latches, a low byte and a high byte, which the processor writes through two separate write strobes sharing one data bus. Bus address decoding and character framing are handled outside the block.

An internal down-counter holds the remaining clocks of the current period. When the counter reaches one, the tick is asserted for that cycle and the counter reloads from the latched divisor. A write to either latch reloads the counter at once from the updated divisor, so a newly programmed rate takes effect in the cycles right after the write and no stale long count is left to run out. A divisor of zero, which is what reset leaves in both latches, keeps the block silent until software programs it.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset both divisor latches read as zero and `sampleTick` stays low until a nonzero divisor is written, including when reset is applied while the generator is running.
- R2: The divisor is the concatenation of the latches, with the latch written through `latchWr[1]` supplying bits 15:8 and the latch written through `latchWr[0]` supplying bits 7:0.
- R3: With a divisor D of 2 or more and no writes, `sampleTick` is high for exactly one clock in every D clocks.
- R4: With a divisor of 1, `sampleTick` is high on every clock.
- R5: With a divisor of 0, `sampleTick` never goes high.
- R6: A write to either latch reloads the counter with the updated divisor at the write edge, so the first tick after it is high in the D-th clock cycle following that edge, whatever count was in progress.
- R7: A write through one bit of `latchWr` leaves the other latch unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the clock being divided |
| rstN | input | 1 | Asynchronous active-low reset |
| latchWr | input | 2 | Write strobes; bit 0 writes the low divisor byte, bit 1 the high byte |
| wrData | input | 8 | Byte written into every latch whose strobe is high |
| sampleTick | output | 1 | One-clock enable pulse at sixteen times the bit rate |

## Verification
The bench builds the block with its default parameters, two latches of eight bits, so the full 16-bit divisor path is in play. Small low-byte divisors give many periods in few cycles, while divisors of 256 and 263 drive a carry into the high latch and check that the bytes combine in the right order. Interrupting a long count with a short divisor shows the immediate reload, and rewriting only the high byte shows the low latch is kept.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  // Strobes from the control to the counter datapath.
  typedef struct packed {
    logic reload;   // load counter from the next divisor value
    logic step;     // decrement counter by one
  } cnt_strobe_t;

endpackage

// File: rtl/baud_tick_ctrl.sv
module baud_tick_ctrl
  import baud_tick_pkg::*;
(
  input  logic        anyWrite,
  input  logic        atOne,
  input  logic        divZero,
  output cnt_strobe_t strobes,
  output logic        tickNow
);

  always_comb begin
    strobes = '0;
    tickNow = 1'b0;
    if (!divZero && atOne) begin
      tickNow = 1'b1;
    end
    if (anyWrite) begin
      strobes.reload = 1'b1;
    end else if (!divZero) begin
      if (atOne) begin
        strobes.reload = 1'b1;
      end else begin
        strobes.step = 1'b1;
      end
    end
  end

endmodule

// File: rtl/baud_tick_dp.sv
module baud_tick_dp
  import baud_tick_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int LATCH_CNT = 2,
  localparam int DIV_W    = BYTE_W * LATCH_CNT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LATCH_CNT-1:0] latchWr,
  input  logic [BYTE_W-1:0]    wrData,
  input  cnt_strobe_t          strobes,
  output logic [DIV_W-1:0]     divisor,
  output logic [DIV_W-1:0]     count,
  output logic                 atOne,
  output logic                 divZero
);

  logic [DIV_W-1:0] nextDiv;

  for (genvar g = 0; g < LATCH_CNT; g++) begin : gLatch
    logic [BYTE_W-1:0] laneQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneQ <= '0;
      end else if (latchWr[g]) begin
        laneQ <= wrData;
      end
    end

    assign divisor[g*BYTE_W +: BYTE_W] = laneQ;
    assign nextDiv[g*BYTE_W +: BYTE_W] = latchWr[g] ? wrData : laneQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobes.reload) begin
      count <= nextDiv;
    end else if (strobes.step) begin
      count <= count - 1'b1;
    end
  end

  assign atOne   = (count == DIV_W'(1));
  assign divZero = (divisor == '0);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int LATCH_CNT = 2,
  localparam int DIV_W    = BYTE_W * LATCH_CNT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LATCH_CNT-1:0] latchWr,
  input  logic [BYTE_W-1:0]    wrData,
  output logic                 sampleTick
);

  cnt_strobe_t      strobes;
  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] count;
  logic             atOne;
  logic             divZero;
  logic             anyWrite;

  assign anyWrite = |latchWr;

  baud_tick_ctrl u_ctrl (
    .anyWrite (anyWrite),
    .atOne    (atOne),
    .divZero  (divZero),
    .strobes  (strobes),
    .tickNow  (sampleTick)
  );

  baud_tick_dp #(
    .BYTE_W    (BYTE_W),
    .LATCH_CNT (LATCH_CNT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .latchWr (latchWr),
    .wrData  (wrData),
    .strobes (strobes),
    .divisor (divisor),
    .count   (count),
    .atOne   (atOne),
    .divZero (divZero)
  );

endmodule

// File: rtl/baud_tick_checker.sv
module baud_tick_checker #(
  parameter int BYTE_W    = 8,
  parameter int LATCH_CNT = 2,
  localparam int DIV_W    = BYTE_W * LATCH_CNT
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [LATCH_CNT-1:0] latchWr,
  input logic [BYTE_W-1:0]    wrData,
  input logic                 sampleTick,
  input logic [DIV_W-1:0]     divisor,
  input logic [DIV_W-1:0]     count
);

  // R5: a zero divisor never produces a tick
  p_zero_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == '0) |-> !sampleTick);

  // R4: divisor of one gives a tick on the next clock too
  p_unit_every_r4: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == DIV_W'(1) && latchWr == '0) |=> sampleTick);

  // R3: tick lasts a single clock when the period is longer than one
  p_single_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && divisor > DIV_W'(1) && latchWr == '0) |=> !sampleTick);

  // R3: counter stays within 1..divisor while a divisor is programmed
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (divisor != '0) |-> (count != '0 && count <= divisor));

  // R6: any write leaves the counter equal to the new divisor
  p_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    (latchWr != '0) |=> (count == divisor));

  // R7: writing only the low latch keeps the high latch
  p_keep_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    (latchWr[0] && !latchWr[LATCH_CNT-1]) |=> $stable(divisor[DIV_W-1 -: BYTE_W]));

  // R2: a low-latch write lands in the low bits
  p_low_lane_r2: assert property (@(posedge clk) disable iff (!rstN)
    latchWr[0] |=> (divisor[BYTE_W-1:0] == $past(wrData)));

endmodule

bind baud_tick_gen baud_tick_checker #(
  .BYTE_W    (BYTE_W),
  .LATCH_CNT (LATCH_CNT)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .latchWr    (latchWr),
  .wrData     (wrData),
  .sampleTick (sampleTick),
  .divisor    (divisor),
  .count      (count)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] latchWr = '0;
  logic [7:0] wrData = '0;
  logic       sampleTick;

  int vecCount = 0;
  int badCount = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk        (clk),
    .rstN       (rstN),
    .latchWr    (latchWr),
    .wrData     (wrData),
    .sampleTick (sampleTick)
  );

  task automatic check(input logic act, input logic exp, input string req, input int cyc);
    vecCount++;
    if (act !== exp) begin
      badCount++;
      $display("FAIL %s cycle %0d: sampleTick=%b expected %b", req, cyc, act, exp);
    end
  endtask

  // Ends at the negedge of the first cycle after the write edge.
  task automatic writeByte(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    latchWr = sel;
    wrData  = data;
    @(negedge clk);
    latchWr = '0;
  endtask

  // Starting in the first cycle after a write, expect ticks every d cycles.
  task automatic expectPeriod(input int d, input int periods, input string req);
    for (int c = 1; c <= d * periods; c++) begin
      if (c > 1) @(negedge clk);
      check(sampleTick, (c % d) == 0, req, c);
    end
  endtask

  task automatic expectQuiet(input int cycles, input string req);
    for (int c = 1; c <= cycles; c++) begin
      @(negedge clk);
      check(sampleTick, 1'b0, req, c);
    end
  endtask

  task automatic testReset();
    // R1: idle out of reset
    expectQuiet(20, "R1");
  endtask

  task automatic testUnit();
    writeByte(2'b01, 8'd1);
    expectPeriod(1, 12, "R4");
  endtask

  task automatic testSmall();
    writeByte(2'b01, 8'd5);
    expectPeriod(5, 4, "R3");
    writeByte(2'b01, 8'd7);
    expectPeriod(7, 3, "R3");
    writeByte(2'b01, 8'd2);
    expectPeriod(2, 5, "R3");
  endtask

  task automatic testTwoByte();
    writeByte(2'b01, 8'd7);
    writeByte(2'b10, 8'd1);
    expectPeriod(263, 2, "R2");
    // R7: clearing the high byte keeps low byte 7
    writeByte(2'b10, 8'd0);
    expectPeriod(7, 3, "R7");
    writeByte(2'b11, 8'd1);
    expectPeriod(257, 2, "R2");
    writeByte(2'b01, 8'd0);
    expectPeriod(256, 2, "R2");
    writeByte(2'b10, 8'd0);
  endtask

  task automatic testReload();
    writeByte(2'b01, 8'd200);
    repeat (50) @(negedge clk);
    writeByte(2'b01, 8'd3);
    expectPeriod(3, 4, "R6");
    // high-byte write also restarts the count
    writeByte(2'b01, 8'd9);
    repeat (4) @(negedge clk);
    writeByte(2'b10, 8'd0);
    expectPeriod(9, 2, "R6");
  endtask

  task automatic testZero();
    writeByte(2'b01, 8'd0);
    expectQuiet(300, "R5");
  endtask

  task automatic testResetMidRun();
    writeByte(2'b01, 8'd4);
    repeat (6) @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expectQuiet(40, "R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sampleTick, 1'b0, "R1", 0);
    rstN = 1'b1;
    testReset();
    testUnit();
    testSmall();
    testTwoByte();
    testReload();
    testZero();
    testResetMidRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vecCount++;
      badCount++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
      $finish;
    end
  end

endmodule